// File: doc/BRIEF.md
# Interrupt vector receive unit

This unit sits beside a processor core and buffers one incoming interrupt vector at a time. An upstream interrupt mapper presents one level-sensitive request line per vector number. When the unit is idle and at least one line is high, it captures the lowest-numbered requesting vector into a three-word data buffer and sets a busy flag. The busy flag doubles as the trap request to the core.

Software inspects the capture through a combinational load port. One space holds the status word and the other holds the three data words. Software releases the buffer through a store port, which writes only the busy bit of the status word.

The unit has no handshake toward the mapper. The request lines are levels, and a refusal is simply the lines staying high. A request that is refused while the unit is busy is taken at the first clock edge at which the busy flag is found clear. The same happens when the captured source withdraws its line. The only back-pressure is therefore the busy flag itself.

Top module: `ivec_recv_unit`

## Requirements
- R1: After reset the trap request is low, the status word reads 0 and every data word reads 0.
- R2: When the busy flag is clear at a clock edge and any request line is high, the status word reads 0x20 from the next cycle on: bit 5 set, all other bits zero. The trap request is high in that same cycle.
- R3: A capture of vector v makes data word 0 equal to 0x7C0 | v, that is tag 0x1F in bits 10:6 and v in the low bits. Data words 1 and 2 read zero.
- R4: Loads with `ld_space`=0 return the status word whatever the address. Loads with `ld_space`=1 return the data word whose index is `ld_addr[5:4]`. Index 3 returns zero, and the other address bits are ignored.
- R5: A store writes `st_data & 0x20` into the status word, effective the next cycle. Storing 0 clears the busy flag and the trap request, while storing all ones leaves the status at exactly 0x20.
- R6: While the busy flag is set, further requests do not change the data words.
- R7: When the request line of the captured vector is low while the busy flag is set, the busy flag and the trap request clear on the next cycle.
- R8: A request refused while busy is captured at the first edge at which the busy flag is clear. If several lines are high at that edge, the lowest vector number is captured.
- R9: When the unit is idle, a store of 0 and a new request in the same cycle result in the request being captured, with busy set and word 0 updated.
- R10: The trap request output always equals status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vec_req | input | NUM_VEC (48) | Level request line per vector number |
| st_en | input | 1 | Store strobe for the status word |
| st_data | input | 64 | Store value; only bit 5 is kept |
| ld_space | input | 1 | Load select: 0 status word, 1 data words |
| ld_addr | input | 8 | Load byte address; bits 5:4 pick the data word |
| ld_rdata | output | 64 | Load result, combinational |
| trap_req | output | 1 | Trap request to the core, equal to the busy flag |

## Verification
Request and store effects appear one clock edge after they are applied. Inputs change at the falling edge, so the busy flag, the trap request and data word 0 are checked at the following falling edge. Load results are combinational and are compared a fraction of a nanosecond after the load address is set, within the same low phase. The refused-then-accepted case spans two edges: one edge for the clear and a second for the capture. The bench expects the new vector only at the second falling edge after the store.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int WORD_W   = 64;
  localparam int BUSY_POS = 5;
  localparam int TAG_POS  = 6;
  localparam logic [4:0] SRC_TAG = 5'h1F;
  localparam int IDX_LO   = 4;

  typedef enum logic {
    SPACE_STATUS = 1'b0,
    SPACE_DATA   = 1'b1
  } ld_space_e;

  function automatic logic [WORD_W-1:0] vec_word(input logic [WORD_W-1:0] v);
    return (WORD_W'(SRC_TAG) << TAG_POS) | v;
  endfunction
endpackage

// File: rtl/ivr_pick.sv
module ivr_pick #(
  parameter int NUM_VEC = 48,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req,
  output logic               any,
  output logic [VEC_W-1:0]   win
);
  always_comb begin
    any = |req;
    win = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req[i]) win = VEC_W'(i);
    end
  end
endmodule

// File: rtl/ivr_hold.sv
module ivr_hold
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_VEC-1:0]  req,
  input  logic                any,
  input  logic [VEC_W-1:0]    win,
  input  logic                st_en,
  input  logic                st_busy,
  output logic                busy,
  output logic [VEC_W-1:0]    cap_vec,
  output logic [WORD_W-1:0]   word0
);
  logic src_live;

  always_comb src_live = req[cap_vec];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cap_vec <= '0;
      word0   <= '0;
    end else if (!busy && any) begin
      busy    <= 1'b1;
      cap_vec <= win;
      word0   <= vec_word(WORD_W'(win));
    end else if (busy && !src_live) begin
      busy <= 1'b0;
    end else if (st_en) begin
      busy <= st_busy;
    end
  end
endmodule

// File: rtl/ivr_rdmux.sv
module ivr_rdmux
  import ivr_pkg::*;
(
  input  logic              ld_space,
  input  logic [1:0]        idx,
  input  logic              busy,
  input  logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] rdata
);
  localparam int NWORDS = 4;
  logic [WORD_W-1:0] bank [NWORDS];

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_bank
      if (g == 0) begin : g_live
        assign bank[g] = word0;
      end else begin : g_zero
        assign bank[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    if (ld_space == SPACE_STATUS) rdata = WORD_W'(busy) << BUSY_POS;
    else                          rdata = bank[idx];
  end
endmodule

// File: rtl/ivec_recv_unit.sv
module ivec_recv_unit
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int ADDR_W  = 8,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] vec_req,
  input  logic               st_en,
  input  logic [63:0]        st_data,
  input  logic               ld_space,
  input  logic [ADDR_W-1:0]  ld_addr,
  output logic [63:0]        ld_rdata,
  output logic               trap_req
);
  logic             any;
  logic [VEC_W-1:0] win;
  logic             busy;
  logic [VEC_W-1:0] cap_vec;
  logic [63:0]      word0;
  logic             unused_addr_bits;
  logic             unused_st_bits;

  assign unused_addr_bits = ^{ld_addr[ADDR_W-1:IDX_LO+2], ld_addr[IDX_LO-1:0]};
  assign unused_st_bits   = ^{st_data[63:BUSY_POS+1], st_data[BUSY_POS-1:0]};

  ivr_pick #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) pick_i (
    .req(vec_req), .any(any), .win(win)
  );

  ivr_hold #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) hold_i (
    .clk(clk), .rst(rst), .req(vec_req), .any(any), .win(win),
    .st_en(st_en), .st_busy(st_data[BUSY_POS]),
    .busy(busy), .cap_vec(cap_vec), .word0(word0)
  );

  ivr_rdmux rdmux_i (
    .ld_space(ld_space), .idx(ld_addr[IDX_LO+1:IDX_LO]),
    .busy(busy), .word0(word0), .rdata(ld_rdata)
  );

  assign trap_req = busy;
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk #(
  parameter int NUM_VEC = 48,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_VEC-1:0] vec_req,
  input logic               st_en,
  input logic [63:0]        st_data,
  input logic               trap_req,
  input logic [VEC_W-1:0]   cap_vec,
  input logic [63:0]        word0
);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_req) |-> ($past(|vec_req) || $past(st_en && st_data[5])));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && $past(trap_req)) |-> $stable(word0));

  // R7
  src_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !vec_req[cap_vec]) |=> !trap_req);

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && st_en && !st_data[5]) |=> !trap_req);

  // R3
  tag_field_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_req) && $past(|vec_req) |-> (word0[10:6] == 5'h1F));

  // R8
  lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && vec_req[0]) |=> (trap_req && word0[5:0] == 6'd0));
endmodule

bind ivec_recv_unit ivr_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .vec_req(vec_req), .st_en(st_en), .st_data(st_data),
  .trap_req(trap_req), .cap_vec(cap_vec), .word0(word0)
);

// File: tb/ivec_recv_unit_tb_top.sv
`timescale 1ns/100ps
module ivec_recv_unit_tb_top;
  localparam int NV = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NV-1:0] vec_req = '0;
  logic          st_en = 1'b0;
  logic [63:0]   st_data = '0;
  logic          ld_space = 1'b0;
  logic [7:0]    ld_addr = '0;
  logic [63:0]   ld_rdata;
  logic          trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 status load, 1 data load, 2 trap pin
    logic [7:0]  addr;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  ivec_recv_unit dut_i (
    .clk(clk), .rst(rst), .vec_req(vec_req), .st_en(st_en), .st_data(st_data),
    .ld_space(ld_space), .ld_addr(ld_addr), .ld_rdata(ld_rdata), .trap_req(trap_req)
  );

  task automatic push(input int kind, input logic [7:0] addr,
                      input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) #0.1;
    #0.1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      #0.1;
      if (q.size() != 0) begin
        item_t it;
        logic [63:0] got;
        it = q.pop_front();
        ld_space = (it.kind == 1);
        ld_addr  = it.addr;
        #0.2;
        got = (it.kind == 2) ? 64'(trap_req) : ld_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                   it.tag, it.kind, it.addr, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    push(0, 8'h00, 64'h0, "R1 status"); push(1, 8'h00, 64'h0, "R1 word0");
    push(2, 8'h00, 64'h0, "R1 trap");
    drain();

    // R2 R3 R4 R10 single arrival
    vec_req[5] = 1'b1;
    step();
    push(0, 8'h00, 64'h20, "R2 status"); push(2, 8'h00, 64'h1, "R10 trap");
    push(1, 8'h00, 64'h7C5, "R3 word0"); push(1, 8'h10, 64'h0, "R3 word1");
    push(1, 8'h20, 64'h0, "R3 word2");
    drain();
    push(1, 8'h30, 64'h0, "R4 index3"); push(1, 8'h07, 64'h7C5, "R4 low bits");
    push(1, 8'hC5, 64'h7C5, "R4 high bits"); push(0, 8'h35, 64'h20, "R4 status addr");
    drain();

    // R6 no overwrite while busy
    vec_req[3] = 1'b1;
    step();
    push(1, 8'h00, 64'h7C5, "R6 word0 kept"); push(2, 8'h00, 64'h1, "R6 trap");
    drain();

    // R5 software clear, R8 pending taken next edge
    st_en = 1'b1; st_data = 64'h0;
    step();
    st_en = 1'b0;
    push(0, 8'h00, 64'h0, "R5 cleared"); push(2, 8'h00, 64'h0, "R5 trap low");
    drain();
    step();
    push(1, 8'h00, 64'h7C3, "R8 lowest pending"); push(2, 8'h00, 64'h1, "R8 trap");
    drain();

    // R7 captured source drops
    vec_req[3] = 1'b0;
    step();
    push(2, 8'h00, 64'h0, "R7 trap low"); push(0, 8'h00, 64'h0, "R7 status");
    drain();
    step();
    push(1, 8'h00, 64'h7C5, "R8 refused taken"); push(2, 8'h00, 64'h1, "R8 trap again");
    drain();
    vec_req[5] = 1'b0;
    step();
    push(2, 8'h00, 64'h0, "R7 trap low 2"); push(1, 8'h00, 64'h7C5, "R7 word0 held");
    drain();

    // R9 store and arrival together while idle
    st_en = 1'b1; st_data = 64'h0; vec_req[40] = 1'b1;
    step();
    st_en = 1'b0;
    push(2, 8'h00, 64'h1, "R9 trap"); push(1, 8'h00, 64'h7E8, "R9 word0");
    drain();

    // R5 store mask
    st_en = 1'b1; st_data = '1;
    step();
    st_en = 1'b0;
    push(0, 8'h00, 64'h20, "R5 mask"); push(1, 8'h00, 64'h7E8, "R5 word0");
    drain();
    vec_req[40] = 1'b0;
    step();
    push(0, 8'h00, 64'h0, "R7 status low"); push(2, 8'h00, 64'h0, "R10 trap low");
    drain();

    // R8 several at once
    vec_req[47] = 1'b1; vec_req[20] = 1'b1; vec_req[10] = 1'b1;
    step();
    push(1, 8'h00, 64'h7CA, "R8 lowest of three"); push(2, 8'h00, 64'h1, "R8 trap 3");
    drain();
    vec_req = '0;
    step();
    push(2, 8'h00, 64'h0, "R7 all dropped");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule